// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a byte-oriented slave on a two-wire SMBus-style bus. It sits in front of a bank of 8-bit registers and reaches them through an internal register pointer. The two bus lines are oversampled on the system clock. The block detects START, repeated START and STOP. It compares a 7-bit device address and acknowledges its own address and every byte it accepts.

Four short transactions are supported:
- **Pointer-only write.** The address with the write flag, followed by one byte. This byte becomes the pointer.
- **Write-byte.** The same as a pointer-only write, followed by one data byte that is stored at the pointer.
- **Receive-byte.** The address with the read flag. The register at the current pointer is returned.
- **Read-byte.** A pointer write, then a repeated START, then a receive.

The first byte of every write always loads the pointer. A read may reuse whatever pointer a previous transaction left.

The register side is a plain read/write port. The block supplies the register index, write data, a one-cycle write pulse and a one-cycle read strobe. Neighbouring logic can use the read strobe to react when a register has been read, for example to clear a sticky status.

If SCL stays low too long in the middle of a transaction, the slave abandons the transaction and releases the bus. A parameter can remove this timer.

Top module: `smb_ptr_slave`

## Requirements
- R1: The 8 bits after a START are taken MSB first. The upper 7 bits are compared with `SLV_ADDR`, and bit 0 is the direction (0 = write, 1 = read). On a match, `sda_oe` is 1 (SDA pulled low) during the ninth SCL pulse as the acknowledge.
- R2: On an address mismatch, the slave gives no acknowledge. It keeps `sda_oe` at 0, makes no register write and leaves the pointer unchanged until the next START.
- R3: In a write transaction, the first byte after the address is acknowledged and loaded into the pointer, which appears on `reg_addr`. It never causes `reg_we`. A pointer-only write followed by STOP therefore only moves the pointer.
- R4: The second byte of a write is acknowledged and stored with a single-cycle `reg_we` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte. Any later bytes in the same transaction are acknowledged and cause no write.
- R5: In a read, the slave sends the register at the current pointer MSB first, and the pointer may come from an earlier transaction. `reg_rdata` is taken in the cycle in which `reg_re` is 1. `sda_oe` is 1 for a 0 bit. The pointer does not change while a byte is being sent.
- R6: After a byte has been sent, a master NACK (SDA high in the ninth pulse) ends the read. A master ACK makes the slave send the same register again, with a new `reg_re` pulse. The pointer does not advance, and `reg_re` and `reg_we` are never 1 together.
- R7: A repeated START (SDA falling while SCL is high, with no STOP before it) begins a new address phase and keeps the pointer. This allows a pointer write to be followed at once by a read of that register.
- R8: `sda_oe` changes only while the synchronised SCL is low. It is 0 during the master's acknowledge slot of a read.
- R9: A STOP (SDA rising while SCL is high) at any point returns the slave to idle with `sda_oe` at 0. A partial byte cut short by a STOP is discarded, and the next transaction works normally.
- R10: When the timer is enabled, the slave abandons a transaction if synchronised SCL stays low for `TOUT_CYCLES` consecutive clocks during that transaction. It releases SDA and ignores the bus until the next START, with no writes and no pointer change.
- R11: While reset is asserted and directly after it, `sda_oe`, `reg_we` and `reg_re` are 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | ADDR_W | Register pointer, used as the register index |
| reg_we | output | 1 | One-cycle write pulse |
| reg_wdata | output | 8 | Byte to store when `reg_we` is 1 |
| reg_re | output | 1 | One-cycle strobe; `reg_rdata` is taken in this cycle |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational |

## Verification
The assertions assume a bus master that changes SDA only while SCL is low, except when it deliberately forms a START or a STOP. They also assume that SCL high and low phases last much longer than the two-flop synchroniser delay, so that an SCL edge is never seen in the same cycle as a START or STOP. They rely on `reg_rdata` settling in the same cycle as `reg_addr`.

The bench model keeps to these assumptions. It holds every SCL phase for 16 clocks and moves SDA 8 clocks after a falling SCL. It drives SDA through a wired-AND with `sda_oe`, and serves reads combinationally from a register array.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_SKIP
   } smb_state_e;

   localparam int unsigned SMB_BYTE_BITS = 8;
   localparam int unsigned SMB_CNT_W     = $clog2(SMB_BYTE_BITS + 1);
   localparam int unsigned SMB_DEV_W     = 7;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_p;
   logic sda_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   // data edges only count as conditions while the clock is steadily high
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
   parameter bit          EN    = 1'b1,
   parameter int unsigned LIMIT = 7_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);

   generate
      if (EN) begin : g_on
         localparam int unsigned CW = $clog2(LIMIT + 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt <= '0;
            else if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
         end

         assign expire = run && (cnt == CW'(LIMIT - 1));
      end else begin : g_off
         assign expire = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
   import smb_ptr_pkg::*;
#(
   parameter logic [6:0]  SLV_ADDR    = 7'h2E,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TOUT_EN     = 1'b1,
   parameter int unsigned TOUT_CYCLES = 7_500_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [7:0]        reg_wdata,
   output logic              reg_re,
   input  logic [7:0]        reg_rdata
);

   localparam logic [SMB_CNT_W-1:0] LAST_BIT = SMB_CNT_W'(SMB_BYTE_BITS);

   generate
      if (ADDR_W < 1 || ADDR_W > SMB_BYTE_BITS) begin : g_bad_addr_w
         $error("smb_ptr_slave: ADDR_W must lie in 1..8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("smb_ptr_slave: SYNC_STAGES must be at least 2");
      end
      if (TOUT_CYCLES < 2) begin : g_bad_tout
         $error("smb_ptr_slave: TOUT_CYCLES must be at least 2");
      end
   endgenerate

   // ---------------- line conditioning ----------------
   logic [1:0] raw_lines;
   logic [1:0] sync_lines;
   assign raw_lines = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_sync
         smb_line_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lines[g]),
            .q     (sync_lines[g])
         );
      end
   endgenerate

   logic scl_s, sda_s;
   assign scl_s = sync_lines[1];
   assign sda_s = sync_lines[0];

   logic scl_rise, scl_fall, start_ev, stop_ev;

   smb_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   // ---------------- byte engine ----------------
   smb_state_e             state;
   logic [7:0]             shreg;
   logic [SMB_CNT_W-1:0]   bitcnt;
   logic                   is_addr;
   logic                   rw;
   logic [1:0]             wr_idx;
   logic [ADDR_W-1:0]      ptr;
   logic                   sda_oe_q;
   logic                   tout;

   smb_low_timer #(
      .EN    (TOUT_EN),
      .LIMIT (TOUT_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (~scl_s && (state != ST_IDLE)),
      .expire (tout)
   );

   // a byte is fetched when an ack slot ends and more data is owed
   logic load_rd;
   assign load_rd = scl_fall && !start_ev && !stop_ev && !tout &&
                    (((state == ST_RX_ACK) && rw) || (state == ST_TX_ACK));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         bitcnt    <= '0;
         is_addr   <= 1'b0;
         rw        <= 1'b0;
         wr_idx    <= '0;
         ptr       <= '0;
         sda_oe_q  <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (start_ev) begin
            state    <= ST_RX;
            is_addr  <= 1'b1;
            bitcnt   <= '0;
            wr_idx   <= '0;
            rw       <= 1'b0;
            sda_oe_q <= 1'b0;
         end else if (stop_ev || tout) begin
            state    <= ST_IDLE;
            sda_oe_q <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + SMB_CNT_W'(1);
                  end else if (scl_fall && (bitcnt == LAST_BIT)) begin
                     bitcnt <= '0;
                     if (is_addr) begin
                        if (shreg[7:1] == SLV_ADDR) begin
                           rw       <= shreg[0];
                           sda_oe_q <= 1'b1;
                           state    <= ST_RX_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else begin
                        if (wr_idx == 2'd0) begin
                           ptr <= shreg[ADDR_W-1:0];
                        end else if (wr_idx == 2'd1) begin
                           reg_we    <= 1'b1;
                           reg_wdata <= shreg;
                        end
                        if (wr_idx != 2'd2) wr_idx <= wr_idx + 2'd1;
                        sda_oe_q <= 1'b1;
                        state    <= ST_RX_ACK;
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     is_addr <= 1'b0;
                     bitcnt  <= '0;
                     if (rw) begin
                        shreg    <= reg_rdata;
                        sda_oe_q <= ~reg_rdata[7];
                        state    <= ST_TX;
                     end else begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + SMB_CNT_W'(1);
                  end else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_TX_ACK;
                     end else begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_oe_q <= ~shreg[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     if (sda_s) state <= ST_SKIP;
                  end else if (scl_fall) begin
                     shreg    <= reg_rdata;
                     sda_oe_q <= ~reg_rdata[7];
                     bitcnt   <= '0;
                     state    <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = sda_oe_q;
   assign reg_addr = ptr;
   assign reg_re   = load_rd;

   // ---------------- assertions ----------------
   assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!sda_oe_q && !reg_we));

   assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX) |-> $stable(ptr));

   assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_we, reg_re}));

   assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_q) |-> !scl_s);

   assert_ackslot_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK) |-> !sda_oe_q);

   assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> ((state == ST_IDLE) && !sda_oe_q));

   assert_tout_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tout |=> ((state == ST_IDLE) && !sda_oe_q && !reg_we));

endmodule

// File: tb/smb_ptr_slave_bench.sv
module smb_ptr_slave_bench;

   localparam int          HP   = 16;
   localparam int          Q    = 8;
   localparam int unsigned TOUT = 300;
   localparam logic [6:0]  DEV  = 7'h2E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_i;
   logic       sda_oe;
   logic [7:0] reg_addr;
   logic       reg_we;
   logic [7:0] reg_wdata;
   logic       reg_re;
   logic [7:0] reg_rdata;
   logic [7:0] mem [256];

   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   int re_cnt = 0;
   int oe_cnt = 0;
   int r8_viol = 0;
   logic oe_prev = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign sda_i     = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   smb_ptr_slave #(
      .SLV_ADDR    (DEV),
      .ADDR_W      (8),
      .SYNC_STAGES (2),
      .TOUT_EN     (1'b1),
      .TOUT_CYCLES (TOUT)
   ) u_smb_ptr_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_i),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   function automatic logic [7:0] initv(input logic [7:0] a);
      return a ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= initv(8'(i));
      end else begin
         if (reg_we) mem[reg_addr] <= reg_wdata;
         if (reg_we) we_cnt <= we_cnt + 1;
         if (reg_re) re_cnt <= re_cnt + 1;
         if (sda_oe) oe_cnt <= oe_cnt + 1;
      end
   end

   // R8 monitor: SDA drive may only move while the bus clock is low
   always @(negedge clk) begin
      if (rst_n && (sda_oe !== oe_prev) && scl_m) r8_viol <= r8_viol + 1;
      oe_prev <= sda_oe;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic seen, output logic oe_hi);
      sda_m = b;
      waitc(Q);
      scl_m = 1'b1;
      waitc(HP / 2);
      seen  = sda_i;
      oe_hi = sda_oe;
      waitc(HP / 2);
      scl_m = 1'b0;
      waitc(Q);
   endtask

   task automatic bus_start();
      sda_m = 1'b1;
      scl_m = 1'b1;
      waitc(HP);
      sda_m = 1'b0;
      waitc(HP);
      scl_m = 1'b0;
      waitc(Q);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1;
      waitc(Q);
      scl_m = 1'b1;
      waitc(HP);
      sda_m = 1'b0;
      waitc(HP);
      scl_m = 1'b0;
      waitc(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      waitc(Q);
      scl_m = 1'b1;
      waitc(HP);
      sda_m = 1'b1;
      waitc(HP);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      logic s, o;
      for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s, o);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s, o;
      send_bits(b, 8);
      clk_bit(1'b1, s, o);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] d, output logic oe_slot);
      logic s, o;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s, o);
         d = {d[6:0], s};
      end
      clk_bit(~m_ack, s, oe_slot);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R11 sda_oe", 32'(sda_oe), 0);
      chk("R11 reg_we", 32'(reg_we), 0);
      chk("R11 reg_re", 32'(reg_re), 0);
      chk("R11 reg_addr", 32'(reg_addr), 0);
   endtask

   task automatic t_write_byte();
      logic a;
      int w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      chk("R1 address ack", 32'(a), 1);
      send_byte(8'h35, a);
      chk("R3 pointer byte ack", 32'(a), 1);
      chk("R3 pointer no write", 32'(we_cnt - w0), 0);
      send_byte(8'hA7, a);
      chk("R4 data ack", 32'(a), 1);
      bus_stop();
      chk("R3 pointer loaded", 32'(reg_addr), 32'h35);
      chk("R4 data stored", 32'(mem[8'h35]), 32'hA7);
      chk("R4 one write", 32'(we_cnt - w0), 1);
   endtask

   task automatic t_send_byte();
      logic a;
      int w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h10, a);
      bus_stop();
      chk("R3 send-byte pointer", 32'(reg_addr), 32'h10);
      chk("R3 send-byte no write", 32'(we_cnt - w0), 0);
   endtask

   task automatic t_receive_byte(input logic [7:0] exp_d);
      logic a, o;
      logic [7:0] d;
      int r0 = re_cnt;
      bus_start();
      send_byte({DEV, 1'b1}, a);
      chk("R1 read address ack", 32'(a), 1);
      recv_byte(1'b0, d, o);
      chk("R8 released in ack slot", 32'(o), 0);
      bus_stop();
      chk("R5 receive-byte data", 32'(d), 32'(exp_d));
      chk("R5 one read strobe", 32'(re_cnt - r0), 1);
   endtask

   task automatic t_read_byte_rs();
      logic a, o;
      logic [7:0] d;
      int w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h35, a);
      bus_rstart();
      send_byte({DEV, 1'b1}, a);
      chk("R7 ack after repeated start", 32'(a), 1);
      recv_byte(1'b0, d, o);
      bus_stop();
      chk("R7 read-byte data", 32'(d), 32'hA7);
      chk("R7 no write", 32'(we_cnt - w0), 0);
   endtask

   task automatic t_multi_read();
      logic a, o;
      logic [7:0] d1, d2;
      int r0 = re_cnt;
      bus_start();
      send_byte({DEV, 1'b1}, a);
      recv_byte(1'b1, d1, o);
      recv_byte(1'b0, d2, o);
      bus_stop();
      chk("R6 first byte", 32'(d1), 32'hA7);
      chk("R6 repeat same register", 32'(d2), 32'hA7);
      chk("R6 two strobes", 32'(re_cnt - r0), 2);
      chk("R6 pointer not advanced", 32'(reg_addr), 32'h35);
   endtask

   task automatic t_extra_bytes();
      logic a;
      int w0 = we_cnt;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h20, a);
      send_byte(8'h11, a);
      send_byte(8'h22, a);
      chk("R4 extra byte acked", 32'(a), 1);
      send_byte(8'h33, a);
      bus_stop();
      chk("R4 first data stored", 32'(mem[8'h20]), 32'h11);
      chk("R4 neighbour untouched", 32'(mem[8'h21]), 32'(initv(8'h21)));
      chk("R4 extras not written", 32'(we_cnt - w0), 1);
   endtask

   task automatic t_mismatch();
      logic a;
      int w0 = we_cnt;
      int o0 = oe_cnt;
      bus_start();
      send_byte({7'h2F, 1'b0}, a);
      chk("R2 no ack on mismatch", 32'(a), 0);
      send_byte(8'h44, a);
      send_byte(8'h55, a);
      bus_stop();
      chk("R2 SDA never driven", 32'(oe_cnt - o0), 0);
      chk("R2 no write", 32'(we_cnt - w0), 0);
      chk("R2 pointer kept", 32'(reg_addr), 32'h20);
   endtask

   task automatic t_stop_mid();
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_bits(8'h40, 3);
      bus_stop();
      chk("R9 released after stop", 32'(sda_oe), 0);
      chk("R9 partial byte dropped", 32'(reg_addr), 32'h20);
   endtask

   task automatic t_timeout();
      logic s, o, a;
      int w0 = we_cnt;
      bus_start();
      send_bits({DEV, 1'b0}, 8);
      waitc(6);
      chk("R1 ack driven", 32'(sda_oe), 1);
      waitc(TOUT + 20);
      chk("R10 released after timeout", 32'(sda_oe), 0);
      clk_bit(1'b1, s, o);
      chk("R10 no ack after timeout", 32'(s), 1);
      send_byte(8'h66, a);
      send_byte(8'h77, a);
      bus_stop();
      chk("R10 no write", 32'(we_cnt - w0), 0);
      chk("R10 pointer kept", 32'(reg_addr), 32'h20);
      chk("R10 register untouched", 32'(mem[8'h66]), 32'(initv(8'h66)));
   endtask

   // ---------------- sequence ----------------
   initial begin
      waitc(5);
      rst_n = 1'b1;
      waitc(3);
      t_reset();
      t_write_byte();
      t_send_byte();
      t_receive_byte(initv(8'h10));
      t_read_byte_rs();
      t_multi_read();
      t_extra_bytes();
      t_mismatch();
      t_stop_mid();
      t_timeout();
      t_receive_byte(8'h11);  // R9 recovery after abort
      chk("R8 SDA moved with SCL high", 32'(r8_viol), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule